// File: doc/BRIEF.md
# Nibble-Addressed Double-Buffered DAC Register

This block is the digital front end of a 10-bit parallel-input voltage DAC. A host with a bus of eight bits or fewer assembles a 12-bit word in three 4-bit input registers: high, middle and low. Two address lines pick the register or registers, and the write is gated by active-low chip-select and write strobes. The top ten bits of the word are the converter code. The bottom two bits are sub-LSB positions that software must write as zero. The code can be loaded as three nibble writes, or as one byte write followed by one nibble write.

A separate active-low load strobe copies the assembled word into the output register. That register drives `code_o` to the converter, so the host can stage a new code without disturbing the output. An active-low clear and the power-on reset both force the output register to zero at once, without waiting for a clock edge. Neither one touches the staged input word. Writes and loads are sampled on the rising edge of the system clock.

Top module: `dac_nibble_reg`

## Requirements
- R1: A write with `addr_i` = 2'b11 stores `data_i[3:0]` as code bits 9..6.
- R2: A write with `addr_i` = 2'b01 stores `data_i[3:0]` as code bits 5..2.
- R3: A write with `addr_i` = 2'b10 stores `data_i[3:0]` in the low register. Bits [3:2] become code bits 1..0. Bits [1:0] are sub-LSB bits that are stored but never reach `code_o`.
- R4: A write with `addr_i` = 2'b00 stores `data_i[3:0]` in the low register and `data_i[7:4]` as code bits 5..2, both on the same edge.
- R5: A write takes effect only on a rising clock edge where `cs_ni` and `wr_ni` are both low. At any other edge the staged word is unchanged.
- R6: `code_o` changes only through a load. When `ldac_ni` is low at a rising edge, the staged word as it stood before that edge appears on `code_o` after the edge. A write on the same edge does not affect what is loaded.
- R7: While `clr_ni` is low, `code_o` is zero immediately, whatever the state of `cs_ni`. Clear overrides a load sampled in the same period.
- R8: `rst_ni` low forces `code_o` to zero asynchronously.
- R9: Clear and reset leave the staged input word intact. A later load transfers the last written values.
- R10: For every address other than 2'b00, `data_i[7:4]` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous on the output register |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Input register select |
| data_i | input | 8 | Shared data bus |
| ldac_ni | input | 1 | Load strobe, active low |
| clr_ni | input | 1 | Clear of the output register, active low, asynchronous |
| code_o | output | 10 | Converter code |

## Verification
The bench writes a load in the same cycle as a high-nibble write. A design that forwarded the new nibble would show the wrong code. Writes are gated with only one of the two strobes low; a design that gated on a single strobe would corrupt the staged word. The bench sets the sub-LSB bits and the unused upper data bits to ones, so a design that leaked them would show a shifted or altered code. It also holds clear low against an active load, and then reloads after clear and after reset. This catches a design that lets the load win over clear, or that wipes the staged word when clearing.

// File: rtl/dac_nibble_pkg.sv
package dac_nibble_pkg;
  typedef enum logic [1:0] {
    SEL_LOW_MID = 2'b00,
    SEL_MID     = 2'b01,
    SEL_LOW     = 2'b10,
    SEL_HIGH    = 2'b11
  } nib_sel_e;

  localparam int unsigned NUM_NIB = 3;
  localparam int unsigned IDX_LOW = 0;
  localparam int unsigned IDX_MID = 1;
  localparam int unsigned IDX_HIGH = 2;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_nibble_pkg::*;
(
  input  logic               cs_ni,
  input  logic               wr_ni,
  input  logic [1:0]         addr_i,
  output logic [NUM_NIB-1:0] en_o,
  output logic               wide_o
);
  logic     wr_act;
  nib_sel_e sel;

  assign wr_act = ~cs_ni & ~wr_ni;
  assign sel    = nib_sel_e'(addr_i);

  always_comb begin
    en_o   = '0;
    wide_o = 1'b0;
    if (wr_act) begin
      unique case (sel)
        SEL_LOW_MID: begin
          en_o[IDX_LOW] = 1'b1;
          en_o[IDX_MID] = 1'b1;
          wide_o        = 1'b1;
        end
        SEL_MID:  en_o[IDX_MID]  = 1'b1;
        SEL_LOW:  en_o[IDX_LOW]  = 1'b1;
        SEL_HIGH: en_o[IDX_HIGH] = 1'b1;
        default:  en_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dac_input_latch.sv
module dac_input_latch
  import dac_nibble_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  localparam int unsigned BUS_W = 2 * NIB_W,
  localparam int unsigned WORD_W = NUM_NIB * NIB_W
) (
  input  logic               clk_i,
  input  logic [NUM_NIB-1:0] en_i,
  input  logic               wide_i,
  input  logic [BUS_W-1:0]   data_i,
  output logic [WORD_W-1:0]  word_o
);
  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    logic [NIB_W-1:0] src;
    logic [NIB_W-1:0] nib_q;

    // only the middle nibble takes the upper byte half, and only in byte mode
    if (i == IDX_MID) begin : g_mux
      assign src = wide_i ? data_i[BUS_W-1:NIB_W] : data_i[NIB_W-1:0];
    end else begin : g_low
      assign src = data_i[NIB_W-1:0];
    end

    // staged data, deliberately untouched by clear and reset
    always_ff @(posedge clk_i) begin
      if (en_i[i]) nib_q <= src;
    end

    assign word_o[i*NIB_W +: NIB_W] = nib_q;
  end
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              ld_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic              zero_n;
  logic [CODE_W-1:0] code_q;

  assign zero_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge zero_n) begin
    if (!zero_n)   code_q <= '0;
    else if (ld_i) code_q <= code_i;
  end

  assign code_o = code_q;

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (code_o == '0));

  p_load_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && clr_ni) |=> (!clr_ni || code_o == $past(code_i)));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && clr_ni) |=> (!clr_ni || $stable(code_o)));
endmodule

// File: rtl/dac_nibble_reg.sv
module dac_nibble_reg
  import dac_nibble_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned CODE_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 wr_ni,
  input  logic [1:0]           addr_i,
  input  logic [2*NIB_W-1:0]   data_i,
  input  logic                 ldac_ni,
  input  logic                 clr_ni,
  output logic [CODE_W-1:0]    code_o
);
  localparam int unsigned WORD_W = NUM_NIB * NIB_W;
  localparam int unsigned SUB_W  = WORD_W - CODE_W;

  logic [NUM_NIB-1:0] en;
  logic               wide;
  logic [WORD_W-1:0]  word;

  dac_wr_decode u_dec (
    .cs_ni  (cs_ni),
    .wr_ni  (wr_ni),
    .addr_i (addr_i),
    .en_o   (en),
    .wide_o (wide)
  );

  dac_input_latch #(.NIB_W(NIB_W)) u_in (
    .clk_i  (clk_i),
    .en_i   (en),
    .wide_i (wide),
    .data_i (data_i),
    .word_o (word)
  );

  // sub-LSB bits stay behind in the staged word
  dac_out_latch #(.CODE_W(CODE_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .ld_i   (~ldac_ni),
    .code_i (word[WORD_W-1:SUB_W]),
    .code_o (code_o)
  );

  p_wr_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || wr_ni) |=> $stable(word));

  p_high_wr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && addr_i == 2'b11) |=>
      (word[WORD_W-1 -: NIB_W] == $past(data_i[NIB_W-1:0])));

  p_byte_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && addr_i == 2'b00) |=>
      (word[2*NIB_W-1:0] == $past(data_i)));
endmodule

// File: tb/dac_nibble_reg_tb_top.sv
module dac_nibble_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, ldac_ni = 1'b1, clr_ni = 1'b1;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [9:0] code_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_nibble_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni),
    .addr_i(addr_i), .data_i(data_i), .ldac_ni(ldac_ni),
    .clr_ni(clr_ni), .code_o(code_o)
  );

  // {cs_n, wr_n, ld_n, addr[1:0], data[7:0], expected code[9:0]}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 2'b11, 8'h0A, 10'h000},  // R1 high=1010
    {3'b001, 2'b01, 8'h05, 10'h000},  // R2 mid=0101
    {3'b001, 2'b10, 8'h0F, 10'h000},  // R3 low=11, sub=11
    {3'b110, 2'b00, 8'h00, 10'h297},  // R6 R3 load
    {3'b001, 2'b00, 8'hC4, 10'h297},  // R4 byte write
    {3'b101, 2'b11, 8'h03, 10'h297},  // R5 cs high
    {3'b011, 2'b11, 8'h03, 10'h297},  // R5 wr high
    {3'b110, 2'b00, 8'h00, 10'h2B1},  // R4 R5 load
    {3'b001, 2'b11, 8'hF3, 10'h2B1},  // R10 upper ignored
    {3'b001, 2'b01, 8'hE9, 10'h2B1},  // R10
    {3'b110, 2'b00, 8'h00, 10'h0E5},  // R10 load
    {3'b000, 2'b11, 8'h0F, 10'h0E5},  // R6 write+load same edge
    {3'b110, 2'b00, 8'h00, 10'h3E5}   // R6 later load
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s code_o=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_ni = 1'b1; wr_ni = 1'b1; ldac_ni = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R8 reset", code_o, 10'h000);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {cs_ni, wr_ni, ldac_ni} = VEC[i][22:20];
      addr_i = VEC[i][19:18];
      data_i = VEC[i][17:10];
      @(negedge clk);
      check($sformatf("R6 vector %0d", i), code_o, VEC[i][9:0]);
    end
    idle();

    // R7 immediate clear with chip selected
    cs_ni = 1'b0;
    #1 clr_ni = 1'b0;
    #0.5 check("R7 async clear", code_o, 10'h000);
    cs_ni = 1'b1;
    // R7 clear beats load
    @(negedge clk);
    ldac_ni = 1'b0;
    @(negedge clk);
    check("R7 clear over load", code_o, 10'h000);
    ldac_ni = 1'b1;
    clr_ni = 1'b1;
    @(negedge clk);
    check("R7 stays zero after release", code_o, 10'h000);
    // R9 reload after clear
    ldac_ni = 1'b0;
    @(negedge clk);
    ldac_ni = 1'b1;
    check("R9 reload after clear", code_o, 10'h3E5);

    // R8 async reset mid-run, R9 staged word kept
    #1 rst_ni = 1'b0;
    #0.5 check("R8 async reset", code_o, 10'h000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 held zero after reset", code_o, 10'h000);
    ldac_ni = 1'b0;
    @(negedge clk);
    ldac_ni = 1'b1;
    check("R9 reload after reset", code_o, 10'h3E5);

    // R3 sub bits toggled alone do not move the code
    cs_ni = 1'b0; wr_ni = 1'b0; addr_i = 2'b10; data_i = 8'h04;
    @(negedge clk);
    idle(); ldac_ni = 1'b0;
    @(negedge clk);
    ldac_ni = 1'b1;
    check("R3 sub bits cleared", code_o, 10'h3E5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule